// File: doc/BRIEF.md
# Pin Trigger and Remote-IRR Controller

This block sits between a bank of raw interrupt input lines and an interrupt delivery stage. Each line passes through a programmable polarity inversion. The block then keeps a pending bit per line and turns pending lines into delivery requests. Each line is configured as edge-sensitive or level-sensitive. A level-sensitive line that has been delivered is held off by a per-line in-service flag. The flag stays set until the delivery stage reports an end-of-interrupt carrying the vector it was given. The block maps that vector back to a line by searching the configured vectors.

The configuration fields come from an external register block: a mask bit, a polarity bit, a trigger-mode bit and a vector per line. A per-line rewrite strobe tells the block that software rewrote the line's lower entry half, which also releases the in-service flag. The output is a one-cycle delivery pulse. It carries the line index, the line's vector and its trigger mode. At most one line is delivered per cycle, and destination resolution happens downstream.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset no delivery is issued, every pending bit and in-service flag is clear, and all outputs read zero.
- R2: The effective level of a line is its raw input XOR its polarity bit (1 = active low). A line with polarity 1 raises a request when its raw input falls.
- R3: An unmasked edge line (trigger bit 0) is delivered exactly once per rising edge of its effective level, however long the level stays high. The delivery pulse carries the line index, the line's vector and a trigger flag of 0.
- R4: An edge arriving while an edge line is masked is discarded, and clearing the mask later produces no delivery.
- R5: An unmasked level line (trigger bit 1) with a high effective level is delivered once, with trigger flag 1, and sets its in-service flag. No further delivery occurs while the flag is set, even with the level held high.
- R6: An end-of-interrupt whose vector matches a level line clears its in-service flag. If that line is still high and unmasked, it is delivered again.
- R7: When several lines share the end-of-interrupt vector, only the lowest-numbered one is released.
- R8: An end-of-interrupt whose vector matches no line has no effect.
- R9: A level line whose input dropped before its end-of-interrupt is not delivered on that end-of-interrupt. It is delivered when it next goes high.
- R10: A masked level line with a high effective level stays pending without delivery, and is delivered once the mask is cleared.
- R11: A rewrite strobe for a line clears its in-service flag, so a still-high unmasked level line is delivered again.
- R12: When several lines need delivery in one cycle, they are delivered one per cycle in ascending index order on consecutive cycles.
- R13: An end-of-interrupt for a line and a new assertion of that line in the same cycle take effect in that order, so the assertion is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NUM_PINS | Raw interrupt input lines |
| cfg_mask | input | NUM_PINS | Per-line mask, 1 = masked |
| cfg_polarity | input | NUM_PINS | Per-line inversion, 1 = active low |
| cfg_level_trig | input | NUM_PINS | Per-line trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NUM_PINS*VEC_W | Per-line vector, line i in bits [i*VEC_W +: VEC_W] |
| tbl_wr_lo | input | NUM_PINS | Per-line strobe: lower entry half rewritten |
| eoi_valid | input | 1 | End-of-interrupt notification valid |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_valid | output | 1 | One-cycle delivery pulse |
| dlv_pin | output | PIN_W | Index of the delivered line |
| dlv_vector | output | VEC_W | Vector of the delivered line |
| dlv_level | output | 1 | Trigger mode of the delivered line |

## Verification
The hardest situation to reach is an end-of-interrupt that coincides with a fresh assertion of the same level line while the line's in-service flag is still set. The stimulus first delivers the line and then drops its input for a few cycles. It then raises the input and issues the matching end-of-interrupt on the same clock edge. The shared-vector case is also awkward. Two level lines are given one vector and both are delivered, then repeated end-of-interrupts must keep releasing only the lower line while the upper one stays silent.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // Effective line level after the programmable inversion.
  function automatic logic eff_level(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

  // Edge line pending bit: a new rise survives a service in the same cycle,
  // a mask discards everything.
  function automatic logic edge_pend_next(input logic pend, input logic rise,
                                          input logic served, input logic masked);
    return ((pend & ~served) | rise) & ~masked;
  endfunction

  // In-service flag: the release (end-of-interrupt or rewrite) is applied
  // first, a service in the same cycle then sets the flag again.
  function automatic logic rirr_next(input logic rirr, input logic clr,
                                     input logic set);
    return set | (rirr & ~clr);
  endfunction

  // A line wants delivery when pending, unmasked and, in level mode, idle.
  function automatic logic want_service(input logic pend, input logic masked,
                                        input trig_e trig, input logic rirr);
    return pend & ~masked & ((trig == TRIG_EDGE) | ~rirr);
  endfunction

endpackage

// File: rtl/pin_trig_cell.sv
module pin_trig_cell
  import pin_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  raw_in,
  input  logic  inv,
  input  trig_e trig,
  input  logic  masked,
  input  logic  rirr_clr,
  input  logic  served,
  output logic  want,
  output logic  pend,
  output logic  rirr
);

  logic eff;
  logic eff_q;
  logic rise;
  logic pend_q;
  logic rirr_q;
  logic pend_d;
  logic rirr_d;

  always_comb begin
    eff  = eff_level(raw_in, inv);
    rise = eff & ~eff_q;
  end

  always_comb begin
    if (trig == TRIG_LEVEL) begin
      pend_d = eff;
    end else begin
      pend_d = edge_pend_next(pend_q, rise, served, masked);
    end
    rirr_d = rirr_next(rirr_q, rirr_clr, served & (trig == TRIG_LEVEL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      eff_q  <= eff;
      pend_q <= pend_d;
      rirr_q <= rirr_d;
    end
  end

  assign want = want_service(pend_q, masked, trig, rirr_q);
  assign pend = pend_q;
  assign rirr = rirr_q;

endmodule

// File: rtl/eoi_lookup.sv
module eoi_lookup #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8
) (
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS*VEC_W-1:0] vec_flat,
  output logic [NUM_PINS-1:0]       hit_oh
);

  logic [NUM_PINS-1:0] match;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cmp
    assign match[i] = eoi_valid & (vec_flat[i*VEC_W +: VEC_W] == eoi_vector);
  end

  // Keep only the lowest-numbered match.
  always_comb begin
    hit_oh = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_oh    = '0;
        hit_oh[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/svc_pick.sv
module svc_pick #(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [NUM_PINS-1:0] req,
  output logic [NUM_PINS-1:0] gnt,
  output logic [IDX_W-1:0]    idx,
  output logic                any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
      end
    end
    any = |req;
  end

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       pin_level,
  input  logic [NUM_PINS-1:0]       cfg_mask,
  input  logic [NUM_PINS-1:0]       cfg_polarity,
  input  logic [NUM_PINS-1:0]       cfg_level_trig,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
  input  logic [NUM_PINS-1:0]       tbl_wr_lo,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  output logic                      dlv_valid,
  output logic [PIN_W-1:0]          dlv_pin,
  output logic [VEC_W-1:0]          dlv_vector,
  output logic                      dlv_level
);

  // Named internal events, also observed by the bound checker.
  logic [NUM_PINS-1:0] svc_req;
  logic [NUM_PINS-1:0] svc_gnt;
  logic [PIN_W-1:0]    svc_idx;
  logic                svc_any;
  logic [NUM_PINS-1:0] eoi_hit;
  logic [NUM_PINS-1:0] rirr_clr;
  logic [NUM_PINS-1:0] rirr_vec;
  logic [NUM_PINS-1:0] pend_vec;
  logic [VEC_W-1:0]    vec_arr [NUM_PINS];

  eoi_lookup #(
    .NUM_PINS (NUM_PINS),
    .VEC_W    (VEC_W)
  ) u_eoi (
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .vec_flat   (cfg_vector),
    .hit_oh     (eoi_hit)
  );

  assign rirr_clr = eoi_hit | tbl_wr_lo;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign vec_arr[i] = cfg_vector[i*VEC_W +: VEC_W];

    pin_trig_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pin_level[i]),
      .inv      (cfg_polarity[i]),
      .trig     (trig_e'(cfg_level_trig[i])),
      .masked   (cfg_mask[i]),
      .rirr_clr (rirr_clr[i]),
      .served   (svc_gnt[i]),
      .want     (svc_req[i]),
      .pend     (pend_vec[i]),
      .rirr     (rirr_vec[i])
    );
  end

  svc_pick #(
    .NUM_PINS (NUM_PINS),
    .IDX_W    (PIN_W)
  ) u_pick (
    .req (svc_req),
    .gnt (svc_gnt),
    .idx (svc_idx),
    .any (svc_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid  <= 1'b0;
      dlv_pin    <= '0;
      dlv_vector <= '0;
      dlv_level  <= 1'b0;
    end else begin
      dlv_valid <= svc_any;
      if (svc_any) begin
        dlv_pin    <= svc_idx;
        dlv_vector <= vec_arr[svc_idx];
        dlv_level  <= cfg_level_trig[svc_idx];
      end
    end
  end

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int NUM_PINS = 8,
  parameter int PIN_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] cand,
  input logic [NUM_PINS-1:0] grant,
  input logic [NUM_PINS-1:0] rirr,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] level,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] eoi_hit,
  input logic                dlv_valid,
  input logic [PIN_W-1:0]    dlv_pin,
  input logic                dlv_level
);

  localparam logic [NUM_PINS-1:0] ONE = NUM_PINS'(1);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R12

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (((grant - ONE) & cand) == '0)); // R12

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~pend) == '0)); // R3

  AST_LEVEL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & level & rirr) == '0)); // R5

  AST_NO_MASKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & mask) == '0)); // R10

  AST_RIRR_AFTER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_level) |-> rirr[dlv_pin]); // R5

  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_hit)); // R7

endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .PIN_W    (PIN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cand      (svc_req),
  .grant     (svc_gnt),
  .rirr      (rirr_vec),
  .pend      (pend_vec),
  .level     (cfg_level_trig),
  .mask      (cfg_mask),
  .eoi_hit   (eoi_hit),
  .dlv_valid (dlv_valid),
  .dlv_pin   (dlv_pin),
  .dlv_level (dlv_level)
);

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/1ps
module pin_irq_ctrl_test;

  localparam int N = 8;
  localparam int VW = 8;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_level = '0;
  logic [N-1:0]  cfg_mask = '0;
  logic [N-1:0]  cfg_polarity = '0;
  logic [N-1:0]  cfg_level_trig = '0;
  logic [N*VW-1:0] cfg_vector = '0;
  logic [N-1:0]  tbl_wr_lo = '0;
  logic          eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic          dlv_valid;
  logic [2:0]    dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic          dlv_level;

  pin_irq_ctrl #(.NUM_PINS(N), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .cfg_mask(cfg_mask),
    .cfg_polarity(cfg_polarity), .cfg_level_trig(cfg_level_trig),
    .cfg_vector(cfg_vector), .tbl_wr_lo(tbl_wr_lo), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_level(dlv_level)
  );

  always #10 clk = ~clk;

  typedef struct {
    int           pin;
    logic [VW-1:0] vec;
    logic         lvl;
    string        req;
    bit           consec;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   fails = 0;
  int   cycle = 0;
  int   last_dlv_cycle = -10;

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (cycle > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): cycle %0d, expected below %0d", cycle, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Monitor: pops the scoreboard on every delivery pulse.
  always @(negedge clk) begin
    if (rst_n && dlv_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL unexpected delivery: got pin %0d vec %h lvl %0d, expected none",
                 dlv_pin, dlv_vector, dlv_level);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (32'(dlv_pin) != e.pin || dlv_vector != e.vec || dlv_level != e.lvl) begin
          fails++;
          $display("FAIL %s: got pin %0d vec %h lvl %0d, expected pin %0d vec %h lvl %0d",
                   e.req, dlv_pin, dlv_vector, dlv_level, e.pin, e.vec, e.lvl);
        end
        if (e.consec && cycle != last_dlv_cycle + 1) begin
          fails++;
          $display("FAIL %s: delivery at cycle %0d, expected cycle %0d",
                   e.req, cycle, last_dlv_cycle + 1);
        end
      end
      last_dlv_cycle = cycle;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_vec(input int p, input logic [VW-1:0] v);
    cfg_vector[p*VW +: VW] = v;
  endtask

  task automatic expect_dlv(input int p, input logic [VW-1:0] v, input logic lvl,
                            input string r, input bit consec);
    exp_t e;
    e.pin = p; e.vec = v; e.lvl = lvl; e.req = r; e.consec = consec;
    expq.push_back(e);
  endtask

  task automatic settle(input string r);
    step(6);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d deliveries still awaited, expected 0", r, expq.size());
      expq.delete();
    end
  endtask

  task automatic send_eoi(input logic [VW-1:0] v);
    eoi_valid = 1'b1;
    eoi_vector = v;
    step(1);
    eoi_valid = 1'b0;
  endtask

  task automatic strobe(input logic [N-1:0] m);
    tbl_wr_lo = m;
    step(1);
    tbl_wr_lo = '0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) set_vec(i, 8'h40 + 8'(i));
    step(4);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    checks++;
    if (dlv_valid !== 1'b0 || dlv_pin !== '0 || dlv_vector !== '0 || dlv_level !== 1'b0) begin
      fails++;
      $display("FAIL R1: outputs %0d/%0d/%h/%0d, expected all zero",
               dlv_valid, dlv_pin, dlv_vector, dlv_level);
    end
    settle("R1");

    // R3: edge line, held high, one delivery with payload
    expect_dlv(3, 8'h43, 1'b0, "R3", 1'b0);
    pin_level[3] = 1'b1;
    step(8);
    pin_level[3] = 1'b0;
    settle("R3");

    // R2: active-low line fires on falling raw input
    pin_level[4] = 1'b1;
    cfg_polarity[4] = 1'b1;
    settle("R2");
    expect_dlv(4, 8'h44, 1'b0, "R2", 1'b0);
    pin_level[4] = 1'b0;
    settle("R2");
    pin_level[4] = 1'b1;
    settle("R2");

    // R4: edge while masked is dropped
    cfg_mask[1] = 1'b1;
    pin_level[1] = 1'b1;
    step(3);
    pin_level[1] = 1'b0;
    step(2);
    cfg_mask[1] = 1'b0;
    settle("R4");

    // R5: level line delivered once while held high
    cfg_level_trig[6] = 1'b1;
    expect_dlv(6, 8'h46, 1'b1, "R5", 1'b0);
    pin_level[6] = 1'b1;
    step(10);
    settle("R5");

    // R8: unmatched end-of-interrupt ignored
    send_eoi(8'h99);
    settle("R8");

    // R6: matching end-of-interrupt redelivers a still-high line
    expect_dlv(6, 8'h46, 1'b1, "R6", 1'b0);
    send_eoi(8'h46);
    settle("R6");

    // R9: input dropped before end-of-interrupt
    pin_level[6] = 1'b0;
    step(2);
    send_eoi(8'h46);
    settle("R9");
    expect_dlv(6, 8'h46, 1'b1, "R9", 1'b0);
    pin_level[6] = 1'b1;
    settle("R9");

    // R13: end-of-interrupt and new assertion in the same cycle
    pin_level[6] = 1'b0;
    step(3);
    expect_dlv(6, 8'h46, 1'b1, "R13", 1'b0);
    pin_level[6] = 1'b1;
    send_eoi(8'h46);
    settle("R13");

    // R11: rewrite strobe releases the in-service flag
    expect_dlv(6, 8'h46, 1'b1, "R11", 1'b0);
    strobe(N'(1) << 6);
    settle("R11");
    pin_level[6] = 1'b0;
    send_eoi(8'h46);
    settle("R11");

    // R10: masked level line waits, delivered on unmask
    cfg_mask[7] = 1'b1;
    cfg_level_trig[7] = 1'b1;
    pin_level[7] = 1'b1;
    settle("R10");
    expect_dlv(7, 8'h47, 1'b1, "R10", 1'b0);
    cfg_mask[7] = 1'b0;
    settle("R10");
    pin_level[7] = 1'b0;
    send_eoi(8'h47);
    settle("R10");

    // R7: shared vector, only the lowest line released
    set_vec(2, 8'h60);
    set_vec(5, 8'h60);
    cfg_level_trig[2] = 1'b1;
    cfg_level_trig[5] = 1'b1;
    expect_dlv(2, 8'h60, 1'b1, "R7", 1'b0);
    expect_dlv(5, 8'h60, 1'b1, "R7", 1'b1);
    pin_level[2] = 1'b1;
    pin_level[5] = 1'b1;
    settle("R7");
    for (int k = 0; k < 2; k++) begin
      expect_dlv(2, 8'h60, 1'b1, "R7", 1'b0);
      send_eoi(8'h60);
      settle("R7");
    end
    pin_level[2] = 1'b0;
    pin_level[5] = 1'b0;
    step(2);
    strobe(N'(8'b0010_0100));
    cfg_level_trig[2] = 1'b0;
    cfg_level_trig[5] = 1'b0;
    set_vec(2, 8'h42);
    set_vec(5, 8'h45);
    settle("R7");

    // R12: simultaneous edges served in ascending order, back to back
    expect_dlv(0, 8'h40, 1'b0, "R12", 1'b0);
    expect_dlv(3, 8'h43, 1'b0, "R12", 1'b1);
    expect_dlv(5, 8'h45, 1'b0, "R12", 1'b1);
    pin_level[0] = 1'b1;
    pin_level[3] = 1'b1;
    pin_level[5] = 1'b1;
    settle("R12");
    pin_level = '0;
    cfg_polarity = '0;
    settle("R12");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule